// File: doc/BRIEF.md
# PLL Phase Lock Detector

This block is a digital lock indicator for a clock-multiplying loop. It compares a reference clock with the loop's feedback clock. Once per reference period it measures how far apart their rising edges fall. It raises a lock flag only after an unbroken run of good measurements. Both clocks are sampled by a faster free-running measurement clock. All measurement is done in that domain, with a resolution of one measurement-clock cycle.

Each reference rising edge closes the previous period and opens a new one. Two distances are recorded. The lead is the time from the latest feedback edge at or before the opening reference edge. The lag is the time from the opening reference edge to the first feedback edge inside the period. The smaller of the two is the phase offset, so either clock may lead. The closing edge compares that offset with a programmable window. A period passes if the offset is strictly inside the window. One bad period drops lock at once and restarts the count. A power-down input clears the detector and holds it idle.

Top module: `pll_lock_det`

## Requirements
- R1: The phase offset of a period is min(lead, lag), counted in `clk_i` cycles between synchronized rising edges. Lag is the distance from the opening reference edge to the first feedback edge at or after it and before the closing reference edge. Lead is the distance from the latest feedback edge at or before the opening reference edge. Both saturate at 255 (CNT_W = 8).
- R2: A period passes only when a feedback edge was seen in it and its offset is strictly less than `win_i`, the value present at the closing reference edge. When `win_i` is 0, no period passes and `lock_o` never rises.
- R3: `lock_o` rises only after more than LOCK_RUN (8) consecutive passing periods, which means on the ninth pass. It changes 3 `clk_i` cycles after the closing reference edge is applied at `ref_clk_i`.
- R4: A failing period clears the run of passes. After a run of eight passes and one fail, nine fresh passes are needed.
- R5: A failing period drops `lock_o` on that same evaluation if it was high.
- R6: `lock_o` is low out of reset. The first reference edge after reset or after power-down is released only opens a period and is not evaluated.
- R7: A reference period that contains no feedback rising edge fails.
- R8: The run counter saturates, so `lock_o` stays high through an arbitrarily long run of passing periods.
- R9: While `pd_i` is high, `lock_o` is low from the next `clk_i` cycle on, and nothing is evaluated.
- R10: A feedback clock that leads the reference is measured through the lead distance, symmetrically with a lagging one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running measurement clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_i | input | 1 | Power-down; synchronous clear and hold |
| ref_clk_i | input | 1 | Reference clock, asynchronous to clk_i |
| fb_clk_i | input | 1 | Feedback clock, asynchronous to clk_i |
| win_i | input | WIN_W (6) | Lock window in clk_i cycles |
| lock_o | output | 1 | Lock indicator |

## Verification
The bench uses the default parameters: 8-bit distance counters, a 6-bit window, a run length of eight and two synchronizer stages. Edge offsets of up to six cycles on either side of a 16-cycle reference period are swept against every window value from 0 to 7. This covers each offset falling just inside, exactly on and outside the window, for both leading and lagging feedback. Further directed timelines cover exactly eight passes followed by a fail, a missing feedback edge, an out-of-window period after lock, a 60-period saturation run and a power-down held across clean edges.

// File: rtl/pll_lock_det_pkg.sv
package pll_lock_det_pkg;
  localparam int unsigned N_CLK   = 2;
  localparam int unsigned REF_IDX = 0;
  localparam int unsigned FB_IDX  = 1;
endpackage

// File: rtl/pll_lock_edge_sync.sv
module pll_lock_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pll_lock_phase_meas.sv
module pll_lock_phase_meas #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned WIN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             ref_rise_i,
  input  logic             fb_rise_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             eval_o,
  output logic             pass_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ref_age_q, fb_age_q, lead_q, lag_q;
  logic             seen_q, armed_q;
  logic [CNT_W-1:0] ref_dist, fb_dist, off;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
    return (x == MAX) ? x : x + 1'b1;
  endfunction

  assign ref_dist = ref_rise_i ? '0 : ref_age_q;
  assign fb_dist  = fb_rise_i  ? '0 : fb_age_q;
  assign off      = (lead_q < lag_q) ? lead_q : lag_q;
  assign eval_o   = ref_rise_i & armed_q & ~pd_i;
  assign pass_o   = seen_q && (off < CNT_W'(win_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_age_q <= MAX;
      fb_age_q  <= MAX;
      lead_q    <= MAX;
      lag_q     <= MAX;
      seen_q    <= 1'b0;
      armed_q   <= 1'b0;
    end else if (pd_i) begin
      ref_age_q <= MAX;
      fb_age_q  <= MAX;
      lead_q    <= MAX;
      lag_q     <= MAX;
      seen_q    <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      ref_age_q <= sat_inc(ref_dist);
      fb_age_q  <= sat_inc(fb_dist);
      if (ref_rise_i) begin
        // open a new period
        lead_q  <= fb_dist;
        seen_q  <= fb_rise_i;
        lag_q   <= fb_rise_i ? '0 : MAX;
        armed_q <= 1'b1;
      end else if (fb_rise_i && !seen_q) begin
        lag_q  <= ref_age_q;
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_lock_run_ctr.sv
module pll_lock_run_ctr #(
  parameter int unsigned LOCK_RUN = 8,
  parameter int unsigned RUN_W    = $clog2(LOCK_RUN + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             eval_i,
  input  logic             pass_i,
  output logic [RUN_W-1:0] run_o,
  output logic             lock_o
);
  localparam logic [RUN_W-1:0] TOP = RUN_W'(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] THR = RUN_W'(LOCK_RUN);

  logic [RUN_W-1:0] run_q;
  logic             lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (pd_i) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (eval_i) begin
      if (pass_i) begin
        run_q  <= (run_q == TOP) ? TOP : run_q + 1'b1;
        lock_q <= (run_q >= THR);
      end else begin
        run_q  <= '0;
        lock_q <= 1'b0;
      end
    end
  end

  assign run_o  = run_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WIN_W       = 6,
  parameter int unsigned LOCK_RUN    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RUN_W      = $clog2(LOCK_RUN + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_i,
  input  logic             ref_clk_i,
  input  logic             fb_clk_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             lock_o
);
  import pll_lock_det_pkg::*;

  logic [N_CLK-1:0] raw, rise;
  logic             eval, pass;
  logic [RUN_W-1:0] run;

  assign raw[REF_IDX] = ref_clk_i;
  assign raw[FB_IDX]  = fb_clk_i;

  for (genvar g = 0; g < N_CLK; g++) begin : g_sync
    pll_lock_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .rise_o(rise[g])
    );
  end

  pll_lock_phase_meas #(.CNT_W(CNT_W), .WIN_W(WIN_W)) i_meas (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pd_i      (pd_i),
    .ref_rise_i(rise[REF_IDX]),
    .fb_rise_i (rise[FB_IDX]),
    .win_i     (win_i),
    .eval_o    (eval),
    .pass_o    (pass)
  );

  pll_lock_run_ctr #(.LOCK_RUN(LOCK_RUN), .RUN_W(RUN_W)) i_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pd_i  (pd_i),
    .eval_i(eval),
    .pass_i(pass),
    .run_o (run),
    .lock_o(lock_o)
  );
endmodule

// File: rtl/pll_lock_det_chk.sv
module pll_lock_det_chk #(
  parameter int unsigned WIN_W    = 6,
  parameter int unsigned LOCK_RUN = 8,
  parameter int unsigned RUN_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_i,
  input logic [WIN_W-1:0] win_i,
  input logic             eval,
  input logic             pass,
  input logic [RUN_W-1:0] run,
  input logic             lock_o
);
  p_pd_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> !lock_o);

  p_fail_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval && !pass && !pd_i) |=> !lock_o);

  p_rise_on_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(eval && pass));

  p_hold_between_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || pd_i)
    !eval |=> $stable(lock_o));

  p_zero_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval && win_i == '0) |-> !pass);

  p_run_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run <= RUN_W'(LOCK_RUN + 1));
endmodule

bind pll_lock_det pll_lock_det_chk #(
  .WIN_W(WIN_W), .LOCK_RUN(LOCK_RUN), .RUN_W(RUN_W)
) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .pd_i  (pd_i),
  .win_i (win_i),
  .eval  (eval),
  .pass  (pass),
  .run   (run),
  .lock_o(lock_o)
);

// File: tb/test_pll_lock_det.sv
`timescale 1ns/1ps
module test_pll_lock_det;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pd_i = 1'b0;
  logic       ref_clk_i = 1'b0;
  logic       fb_clk_i = 1'b0;
  logic [5:0] win_i = '0;
  logic       lock_o;

  int n_chk = 0;
  int n_fail = 0;

  int rt[64];
  int ft[64];
  int nr, nf;
  bit expl[64];

  always #10 clk_i = ~clk_i;

  pll_lock_det i_pll_lock_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pd_i(pd_i), .ref_clk_i(ref_clk_i),
    .fb_clk_i(fb_clk_i), .win_i(win_i), .lock_o(lock_o)
  );

  task automatic chk(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lock_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // timeline of one scenario: T period, n edges, fb offset d
  task automatic build(input int T, input int n, input int d,
                       input int miss_k, input int bad_k, input int bad_d);
    nr = n; nf = 0;
    for (int k = 0; k < n; k++) begin
      rt[k] = 16 + k * T;
      if (k != miss_k) begin
        ft[nf] = rt[k] + ((k == bad_k) ? bad_d : d);
        nf++;
      end
    end
  endtask

  task automatic model(input int win);
    int run = 0;
    bit lk = 0;
    expl[0] = 0;
    for (int j = 1; j < nr; j++) begin
      int p = rt[j-1];
      int q = rt[j];
      bit seen = 0;
      int lag = 255;
      int lead = 255;
      int off;
      bit pass;
      for (int i = 0; i < nf; i++) begin
        if (ft[i] >= p && ft[i] < q && !seen) begin seen = 1; lag = ft[i] - p; end
        if (ft[i] <= p) lead = (p - ft[i] > 255) ? 255 : p - ft[i];
      end
      off = (lead < lag) ? lead : lag;
      pass = seen && (off < win);
      if (pass) begin
        run = (run >= 9) ? 9 : run + 1;
        lk = (run > 8);
      end else begin
        run = 0; lk = 0;
      end
      expl[j] = lk;
    end
  endtask

  task automatic run_scenario(input int win, input string tag);
    int t_end;
    model(win);
    win_i = 6'(win);
    @(negedge clk_i); pd_i = 1'b1; ref_clk_i = 0; fb_clk_i = 0;
    @(negedge clk_i); chk(lock_o, 1'b0, "R9");
    repeat (2) @(negedge clk_i);
    pd_i = 1'b0;
    t_end = rt[nr-1] + 8;
    for (int t = 0; t <= t_end; t++) begin
      bit r, f;
      @(negedge clk_i);
      for (int j = 0; j < nr; j++) begin
        if (t == rt[j] + 4) begin
          if (j == 0) chk(lock_o, expl[j], "R6");
          else if (expl[j] && !expl[j-1]) chk(lock_o, expl[j], "R3");
          else if (!expl[j] && expl[j-1]) chk(lock_o, expl[j], "R5");
          else chk(lock_o, expl[j], tag);
        end
      end
      r = 0; f = 0;
      for (int k = 0; k < nr; k++) if (t >= rt[k] && t < rt[k] + 2) r = 1;
      for (int k = 0; k < nf; k++) if (t >= ft[k] && t < ft[k] + 2) f = 1;
      ref_clk_i = r; fb_clk_i = f;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(lock_o, 1'b0, "R6");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(lock_o, 1'b0, "R6");

    // sweep offset and window: R1 R2 R10
    for (int w = 0; w <= 7; w++) begin
      for (int d = -6; d <= 6; d++) begin
        build(16, 12, d, -1, -1, 0);
        if (w == 0) run_scenario(w, "R2");
        else if (d < 0) run_scenario(w, "R10");
        else run_scenario(w, "R1");
      end
    end

    // R4: eight passes, one fail, then restart
    build(14, 22, 1, -1, 8, 9);
    run_scenario(4, "R4");
    build(14, 22, 1, 8, -1, 0);
    run_scenario(4, "R4");

    // R7: missing feedback edge after lock
    build(16, 24, 2, 12, -1, 0);
    run_scenario(4, "R7");

    // R5: out-of-window period after lock
    build(16, 24, 2, -1, 14, 8);
    run_scenario(3, "R5");

    // R8: long run stays locked
    build(12, 60, 1, -1, -1, 0);
    run_scenario(5, "R8");

    // R9: power-down held across clean edges
    win_i = 6'd10;
    @(negedge clk_i); pd_i = 1'b1;
    for (int p = 0; p < 15; p++) begin
      for (int c = 0; c < 12; c++) begin
        @(negedge clk_i);
        ref_clk_i = (c < 2);
        fb_clk_i  = (c >= 1 && c < 3);
      end
      chk(lock_o, 1'b0, "R9");
    end
    ref_clk_i = 0; fb_clk_i = 0;
    repeat (6) @(negedge clk_i);
    pd_i = 1'b0;
    build(16, 12, 1, -1, -1, 0);
    run_scenario(4, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule